// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block runs ahead of an instruction consumer and keeps a six-byte queue filled with instruction bytes. It forms a 20-bit physical fetch address by shifting a 16-bit code segment value left by four bits and adding a 16-bit prefetch offset. It issues word-wide read requests on a simple valid/ready request channel, and only when the queue has room for a whole word. Returned words are split into bytes and appended to the queue. The consumer drains the queue one byte per valid/ready handshake.

When the consumer redirects the instruction stream, it raises the flush input together with the new offset. The queue is emptied, any read still in flight is marked stale and its data discarded on return, and prefetching resumes at the new offset. The address sent to memory is always word aligned. When the offset is odd, only the high byte of the returned word belongs to the stream.

Top module: `fetch_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid_o` is 0 and `req_valid_o` is 1 with the address formed from `cs_i` and offset 0x0000.
- R2: `req_addr_o` equals (`cs_i` * 16 + prefetch offset) modulo 2^20 with bit 0 forced to 0.
- R3: The queue never holds more than 6 bytes, and `req_valid_o` is 1 exactly when no read is outstanding, at least 2 byte slots are free and `flush_i` is 0.
- R4: For a response to a read at an even offset, byte `resp_data_i[7:0]` is queued first, then `resp_data_i[15:8]`, and the offset advances by 2.
- R5: For a response to a read at an odd offset, only `resp_data_i[15:8]` is queued and the offset advances by 1.
- R6: Bytes leave in the order they were queued, one per cycle in which `out_valid_o` and `out_ready_i` are both 1; `out_valid_o` is 0 while the queue is empty.
- R7: A flush empties the queue, sets the offset to `flush_off_i`, and causes the response to a read accepted before the flush to be dropped.
- R8: The prefetch offset wraps within 16 bits (odd offset 0xFFFF is followed by 0x0000).
- R9: A byte leaving and bytes arriving in the same cycle are both honoured, and the occupancy changes by their net amount.
- R10: At most one read is outstanding: the cycle after a request is accepted `req_valid_o` is 0, and an unaccepted request keeps its address while `cs_i` is unchanged and no flush occurs.
- R11: The carry out of bit 19 of the address sum is discarded (segment 0xFFFF with offset 0x0010 gives address 0x00000).
- R12: In a flush cycle `out_valid_o` and `req_valid_o` are 0, and a response arriving in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 16 | Code segment value |
| flush_i | input | 1 | Restart prefetching at `flush_off_i` |
| flush_off_i | input | 16 | New prefetch offset used with a flush |
| req_valid_o | output | 1 | Word read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 20 | Word-aligned physical read address |
| resp_valid_i | input | 1 | Read data valid |
| resp_data_i | input | 16 | Read data word, low byte at the even address |
| out_valid_o | output | 1 | A queued byte is available |
| out_ready_i | input | 1 | Consumer takes the byte |
| out_byte_o | output | 8 | Byte at the head of the queue |

## Verification
Two pairs of events can land in one cycle. A refill write can coincide with a consumer read, and a flush can coincide with a returning response. The bench provokes the first by reading on most cycles with zero-latency memory, and it judges the result by comparing every byte leaving the queue against a byte-accurate queue model. The second comes from vectors that flush while a response is due. The model discards that response and any stale one, so a single wrongly kept byte shows up as a miscompare on the next byte read.

// File: rtl/fetch_queue_pkg.sv
package fetch_queue_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_e;
endpackage

// File: rtl/fq_addr_gen.sv
module fq_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int SHIFT = PA_W - SEG_W;
  localparam int OPAD  = PA_W - OFF_W;

  logic [PA_W-1:0] seg_sh;
  logic [PA_W-1:0] off_ext;

  assign seg_sh  = {seg_i, {SHIFT{1'b0}}};
  assign off_ext = {{OPAD{1'b0}}, off_i};
  // sum truncated to PA_W: carry out dropped
  assign paddr_o = seg_sh + off_ext;
endmodule

// File: rtl/fq_byte_fifo.sv
module fq_byte_fifo
  import fetch_queue_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic [1:0]                     wr_n_i,
  input  byte_t                          wr_b0_i,
  input  byte_t                          wr_b1_i,
  input  logic                           rd_i,
  output byte_t                          rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  byte_t           slot_q [DEPTH];
  logic [IW-1:0]   wr_ptr_q, rd_ptr_q, wr_ptr_p1;
  logic [CW-1:0]   cnt_q;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  assign wr_ptr_p1 = wrap_inc(wr_ptr_q);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (!clr_i) begin
        if (wr_n_i != 2'd0 && wr_ptr_q == IW'(g)) begin
          slot_q[g] <= wr_b0_i;
        end else if (wr_n_i == 2'd2 && wr_ptr_p1 == IW'(g)) begin
          slot_q[g] <= wr_b1_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      case (wr_n_i)
        2'd1:    wr_ptr_q <= wr_ptr_p1;
        2'd2:    wr_ptr_q <= wrap_inc(wr_ptr_p1);
        default: wr_ptr_q <= wr_ptr_q;
      endcase
      if (rd_i) rd_ptr_q <= wrap_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(wr_n_i) - CW'(rd_i);
    end
  end

  assign rd_data_o = slot_q[rd_ptr_q];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/fq_fetch_ctrl.sv
module fq_fetch_ctrl
  import fetch_queue_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int CW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [OFF_W-1:0]  flush_off_i,
  input  logic [CW-1:0]     free_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  input  logic              resp_valid_i,
  input  logic [WORD_W-1:0] resp_data_i,
  output logic [OFF_W-1:0]  off_o,
  output push_e             push_n_o,
  output byte_t             push_b0_o,
  output byte_t             push_b1_o
);
  logic             pend_q;   // read accepted, response not yet seen
  logic             drop_q;   // outstanding response is stale
  logic [OFF_W-1:0] off_q;
  logic             fire, take, odd;

  assign odd         = off_q[0];
  assign req_valid_o = !pend_q && (free_i >= CW'(2)) && !flush_i;
  assign fire        = req_valid_o && req_ready_i;
  assign take        = resp_valid_i && pend_q && !drop_q && !flush_i;

  always_comb begin
    push_n_o  = PUSH_NONE;
    push_b0_o = resp_data_i[BYTE_W-1:0];
    push_b1_o = resp_data_i[WORD_W-1:BYTE_W];
    if (take) begin
      if (odd) begin
        push_n_o  = PUSH_ONE;
        push_b0_o = resp_data_i[WORD_W-1:BYTE_W];
      end else begin
        push_n_o  = PUSH_TWO;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      off_q  <= '0;
    end else if (flush_i) begin
      off_q  <= flush_off_i;
      pend_q <= pend_q && !resp_valid_i;
      drop_q <= pend_q && !resp_valid_i;
    end else begin
      if (fire) begin
        pend_q <= 1'b1;
      end else if (resp_valid_i && pend_q) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
      end
      if (take) off_q <= off_q + (odd ? OFF_W'(1) : OFF_W'(2));
    end
  end

  assign off_o = off_q;
endmodule

// File: rtl/fetch_queue.sv
module fetch_queue
  import fetch_queue_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic              flush_i,
  input  logic [OFF_W-1:0]  flush_off_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [PA_W-1:0]   req_addr_o,
  input  logic              resp_valid_i,
  input  logic [WORD_W-1:0] resp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_byte_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic [OFF_W-1:0] off;
  logic [PA_W-1:0]  paddr;
  logic [CW-1:0]    q_cnt, q_free;
  push_e            push_n;
  byte_t            push_b0, push_b1;
  logic             pop;

  assign q_free      = CW'(DEPTH) - q_cnt;
  assign out_valid_o = (q_cnt != '0) && !flush_i;
  assign pop         = out_valid_o && out_ready_i;
  assign req_addr_o  = {paddr[PA_W-1:1], 1'b0};

  fq_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_agen (
    .seg_i   (cs_i),
    .off_i   (off),
    .paddr_o (paddr)
  );

  fq_fetch_ctrl #(.OFF_W(OFF_W), .CW(CW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .flush_off_i  (flush_off_i),
    .free_i       (q_free),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .resp_valid_i (resp_valid_i),
    .resp_data_i  (resp_data_i),
    .off_o        (off),
    .push_n_o     (push_n),
    .push_b0_o    (push_b0),
    .push_b1_o    (push_b1)
  );

  fq_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (flush_i),
    .wr_n_i    (push_n),
    .wr_b0_i   (push_b0),
    .wr_b1_i   (push_b1),
    .rd_i      (pop),
    .rd_data_o (out_byte_o),
    .cnt_o     (q_cnt)
  );
endmodule

// File: rtl/fetch_queue_chk.sv
module fetch_queue_chk #(
  parameter int DEPTH = 6,
  parameter int PA_W  = 20,
  parameter int SEG_W = 16,
  parameter int CW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic [SEG_W-1:0] cs_i,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [PA_W-1:0]  req_addr_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [CW-1:0]    q_cnt,
  input logic [1:0]       push_n
);
  logic past_ok;
  logic pop;

  assign pop = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_cnt) <= DEPTH);

  assert_req_room_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (int'(q_cnt) <= DEPTH-2));

  assert_one_fetch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (flush_i || !$stable(cs_i) || (req_valid_o && $stable(req_addr_o))));

  assert_flush_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!out_valid_o && !req_valid_o));

  assert_flush_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);

  assert_net_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(flush_i)) |->
      (int'(q_cnt) == int'($past(q_cnt)) + int'($past(push_n)) - int'($past(pop))));
endmodule

bind fetch_queue fetch_queue_chk #(
  .DEPTH(DEPTH), .PA_W(PA_W), .SEG_W(SEG_W), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .cs_i        (cs_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .q_cnt       (q_cnt),
  .push_n      (push_n)
);

// File: tb/sim_fetch_queue.sv
`timescale 1ns/1ps
module sim_fetch_queue;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cs_i = 16'h2000;
  logic        flush_i = 1'b0;
  logic [15:0] flush_off_i = '0;
  logic        req_valid_o, req_ready_i = 1'b0;
  logic [19:0] req_addr_o;
  logic        resp_valid_i = 1'b0;
  logic [15:0] resp_data_i = '0;
  logic        out_valid_o, out_ready_i = 1'b0;
  logic [7:0]  out_byte_o;

  always #2.5 clk_i = ~clk_i;

  fetch_queue u0 (.*);

  typedef struct packed {
    logic [15:0] cs;
    logic [15:0] off;
    logic [3:0]  lat;
    logic [7:0]  popm;
    logic [7:0]  rdym;
    logic [7:0]  ncyc;
    logic [19:0] first;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h1000, 16'h0000, 4'd0, 8'hFF, 8'hFF, 8'd40, 20'h10000},
    '{16'h1234, 16'h0011, 4'd1, 8'hAA, 8'hFF, 8'd40, 20'h12350},
    '{16'hFFFF, 16'h0010, 4'd2, 8'h0F, 8'hFF, 8'd40, 20'h00000},
    '{16'h0000, 16'hFFFF, 4'd0, 8'h00, 8'hFF, 8'd20, 20'h0FFFE},
    '{16'hABCD, 16'h8001, 4'd3, 8'h92, 8'hB5, 8'd50, 20'hB3CD0},
    '{16'h0F00, 16'h7FFE, 4'd0, 8'hFF, 8'hFF, 8'd30, 20'h16FFE}
  };

  int nchk = 0, nfail = 0;
  logic [7:0]  mq [16];
  int          mh = 0, mt = 0, mc = 0;
  logic [15:0] exp_off = '0;
  logic        pend = 0, stale = 0, want_first = 0, both_seen = 0;
  int          lcnt = 0;
  logic [19:0] paddr = '0, first_exp = '0;
  int          cur_lat = 0;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
  endfunction

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return {mem_byte({a[19:1], 1'b1}), mem_byte({a[19:1], 1'b0})};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mpush(input logic [7:0] b);
    mq[mt] = b; mt = (mt + 1) % 16; mc++;
  endtask

  task automatic cyc(input logic fl, input logic [15:0] fo, input logic pop, input logic rdy);
    logic pend_now, got, ov, fire;
    logic [15:0] w;
    logic [19:0] ea;
    @(negedge clk_i);
    flush_i = fl; flush_off_i = fo; out_ready_i = pop; req_ready_i = rdy;
    pend_now = pend; got = 0; resp_valid_i = 0; w = '0;
    if (pend) begin
      if (lcnt == 0) begin
        got = 1; w = mem_word(paddr);
        resp_valid_i = 1; resp_data_i = w;
      end else lcnt--;
    end
    #1;
    // R3: request only with room, nothing in flight, no flush
    chk("R3 req_valid", req_valid_o, !pend_now && (6 - mc >= 2) && !fl);
    ea = ({cs_i, 4'h0} + {4'h0, exp_off}) & 20'hFFFFE;
    if (req_valid_o) chk("R2 req_addr", req_addr_o, ea);
    ov = (mc != 0) && !fl;
    chk("R6/R12 out_valid", out_valid_o, ov);
    if (ov && pop) chk("R6 byte order", out_byte_o, mq[mh]);
    fire = req_valid_o && rdy;
    if (fire && want_first) begin
      chk("R2/R8/R11 first addr", req_addr_o, first_exp);
      want_first = 0;
    end
    if (fl) begin
      mh = 0; mt = 0; mc = 0; exp_off = fo;
      if (got) begin pend = 0; stale = 0; end   // R12 response dropped
      else stale = pend_now;                    // R7 in-flight dropped
    end else begin
      if (ov && pop) begin mh = (mh + 1) % 16; mc--; end
      if (got) begin
        pend = 0;
        if (!stale) begin
          if (ov && pop) both_seen = 1;
          if (exp_off[0]) begin               // R5
            mpush(w[15:8]); exp_off = exp_off + 16'd1;
          end else begin                      // R4
            mpush(w[7:0]); mpush(w[15:8]); exp_off = exp_off + 16'd2;
          end
        end
        stale = 0;
      end
      if (fire) begin pend = 1; paddr = req_addr_o; lcnt = cur_lat; end
    end
    if (mc > 6) chk("R3 occupancy", mc, 6);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 reset out_valid", out_valid_o, 0);
    chk("R1 reset req_valid", req_valid_o, 1);
    chk("R1 reset addr", req_addr_o, 20'h20000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 post-reset addr", req_addr_o, 20'h20000);
    chk("R1 post-reset out_valid", out_valid_o, 0);

    foreach (VECS[i]) begin
      cs_i = VECS[i].cs;
      cur_lat = int'(VECS[i].lat);
      first_exp = VECS[i].first;
      want_first = 1;
      cyc(1'b1, VECS[i].off, 1'b0, VECS[i].rdym[0]);
      for (int c = 1; c < int'(VECS[i].ncyc); c++)
        cyc(1'b0, 16'h0, VECS[i].popm[c % 8], VECS[i].rdym[c % 8]);
      chk("R1-anchor first fetch seen (R7)", want_first, 0);
    end

    // R7/R12: flush while a slow response is due, then flush on its return cycle
    cs_i = 16'h0300; cur_lat = 3;
    cyc(1'b1, 16'h0004, 1'b0, 1'b1);
    cyc(1'b0, 16'h0, 1'b0, 1'b1);
    cyc(1'b1, 16'h0020, 1'b0, 1'b1);
    for (int c = 0; c < 10; c++) cyc(1'b0, 16'h0, c[0], 1'b1);
    while (!(pend && lcnt == 0)) cyc(1'b0, 16'h0, 1'b0, 1'b1);
    cyc(1'b1, 16'h0041, 1'b0, 1'b1);
    for (int c = 0; c < 20; c++) cyc(1'b0, 16'h0, 1'b1, 1'b1);

    // R3/R5: odd start, no consumer: fills to 5 bytes and stops requesting
    cs_i = 16'h0040; cur_lat = 2;
    cyc(1'b1, 16'h0005, 1'b0, 1'b1);
    for (int c = 0; c < 25; c++) cyc(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R3 queue stalls at 5", mc, 5);
    chk("R3 no request when full", req_valid_o, 0);
    for (int c = 0; c < 30; c++) cyc(1'b0, 16'h0, 1'b1, 1'b1);

    chk("R9 read and refill in same cycle", both_seen, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule